// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects eight interrupt request lines, picks the most urgent one that is not masked, and signals the processor on a single interrupt output. The processor answers with an acknowledge pulse. The controller then records the chosen line as in service and presents an eight-bit vector: a software-set base plus the line number. Software finishes service with an end-of-interrupt command. The command can name a level, or it can clear whatever in-service level is most urgent.

Software reaches the controller through a two-offset byte bus. Offset 1 carries the mask register. Offset 0 carries command bytes, and the controller decodes them by bit 4, then by bit 3:

- An initialization byte sets the vector base and brings the controller out of its idle state.
- An end-of-interrupt byte finishes service of a line.
- A control byte chooses what offset 0 reads back. It can also arm a load of the per-line trigger register, which selects edge or level detection for each line.

A small command state machine has three states. It starts in `ST_UNINIT`, where no interrupt is delivered. It moves from `ST_UNINIT` to `ST_RUN` on an initialization byte. It moves from `ST_RUN` to `ST_TRIG_ARM` on a control byte with bit 2 set. It returns from `ST_TRIG_ARM` to `ST_RUN` on the next offset-1 write, which then loads the trigger register instead of the mask, or on an initialization byte. An initialization byte written in `ST_RUN` leaves the machine in `ST_RUN`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_out` is 0, `vector_out` is 0x00, and the mask, trigger (all edge), in-service and edge-latch registers are all zero. The controller is in `ST_UNINIT` and asserts no interrupt until an initialization byte arrives.
- R2: A write to offset 0 with bit 4 = 1 is an initialization byte. It loads the vector base from data bits 7:3, clears every in-service bit and every edge latch, and leaves the state machine in `ST_RUN`.
- R3: A write to offset 1 outside `ST_TRIG_ARM` loads the mask register, which reads back at offset 1. A mask bit of 1 stops that line from raising `int_out` or being acknowledged.
- R4: A write to offset 0 with bit 4 = 0 and bit 3 = 1 is a control byte. It is ignored in `ST_UNINIT`. Bits 1:0 choose the offset-0 readback: 0 gives the in-service bits, 1 gives the pending requests, 2 gives the trigger register, and 3 gives the in-service bits. Bit 2 = 1 arms a trigger load: the next offset-1 write goes to the trigger register (bit = 1 selects level, 0 selects edge) and leaves the mask unchanged.
- R5: Priority is fixed, with line 0 the highest and line 7 the lowest. `int_out` is high, with no register delay, exactly when the controller is running and the lowest-numbered unmasked pending line has a lower number than every set in-service bit. Equal and lower priority requests wait.
- R6: An acknowledge pulse while `int_out` is high sets the in-service bit of the chosen line and clears its edge latch. On the next cycle, `vector_out` shows {base, line number}.
- R7: An acknowledge pulse while `int_out` is low gives `vector_out` = {base, 3'b111} on the next cycle and sets no in-service bit.
- R8: An offset-0 byte with bits 7:5 = 011 and bits 4:3 = 00 is a specific end-of-interrupt. It clears only the in-service bit named by bits 2:0. If that bit is already clear, nothing changes.
- R9: The byte 0x20 (bits 7:5 = 001, bits 4:3 = 00) is a non-specific end-of-interrupt. It clears the lowest-numbered set in-service bit.
- R10: On an edge line, a rising edge is latched and shows as pending from the following cycle. It stays pending after the input falls, until that line is acknowledged. After an end-of-interrupt, the line is not delivered again without a new rising edge.
- R11: On a level line, pending follows the input directly. A line still held high after its end-of-interrupt raises `int_out` again at once.
- R12: An offset-0 byte with bits 4:3 = 00 and bits 7:5 other than 001 or 011 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_addr | input | 1 | Offset select: 0 = command/status, 1 = mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| irq_in | input | 8 | Interrupt request lines 0 to 7 |
| inta | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vector_out | output | 8 | Vector captured at the last acknowledge |

## Verification
A stuck or wrongly set in-service bit shows on `int_out` in the same cycle. It either blocks a request that should pass or lets through one that should wait. It also shows at the offset-0 readback with the in-service view selected. A lost or stale edge latch shows in the cycle after its rising edge, through `int_out` and the pending readback. A wrong base or line choice shows on `vector_out` one cycle after the acknowledge. The reference model therefore compares all three outputs on every clock, so any divergence is reported within one cycle of its cause.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NL     = 8;
    localparam int LW     = $clog2(NL);
    localparam int DW     = 8;
    localparam int BASE_W = DW - LW;

    typedef logic [NL-1:0] line_vec_t;

    typedef enum logic [1:0] {
        ST_UNINIT   = 2'd0,
        ST_RUN      = 2'd1,
        ST_TRIG_ARM = 2'd2
    } ctl_state_e;

    // index of the lowest-numbered set bit (most urgent line); 0 when none set
    function automatic logic [LW-1:0] first_set(input line_vec_t v);
        logic [LW-1:0] r;
        r = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (v[i]) r = LW'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_cmd_fsm.sv
module irq_cmd_fsm
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    output logic              running,
    output line_vec_t         mask_q,
    output line_vec_t         trig_q,
    output logic [BASE_W-1:0] base_q,
    output logic [1:0]        rdsel_q,
    output logic              init_p,
    output logic              ns_eoi_p,
    output logic              sp_eoi_p,
    output logic [LW-1:0]     eoi_lvl
);

    ctl_state_e st_q, st_d;
    logic cmd_wr, data_wr, is_icw, is_ocw2, is_ocw3;

    always_comb begin
        cmd_wr  = wr && !addr;
        data_wr = wr && addr;
        is_icw  = cmd_wr && wdata[4];
        is_ocw2 = cmd_wr && !wdata[4] && !wdata[3];
        is_ocw3 = cmd_wr && !wdata[4] && wdata[3];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_UNINIT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_UNINIT:   if (is_icw) st_d = ST_RUN;
            ST_RUN:      if (is_ocw3 && wdata[2]) st_d = ST_TRIG_ARM;
            ST_TRIG_ARM: if (data_wr || is_icw) st_d = ST_RUN;
            default:     st_d = ST_UNINIT;
        endcase
    end

    always_comb begin
        running  = (st_q != ST_UNINIT);
        init_p   = is_icw;
        ns_eoi_p = is_ocw2 && running && (wdata[7:5] == 3'b001);
        sp_eoi_p = is_ocw2 && running && (wdata[7:5] == 3'b011);
        eoi_lvl  = wdata[LW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            trig_q  <= '0;
            base_q  <= '0;
            rdsel_q <= '0;
        end else begin
            if (data_wr && st_q != ST_TRIG_ARM) mask_q <= wdata[NL-1:0];
            if (data_wr && st_q == ST_TRIG_ARM) trig_q <= wdata[NL-1:0];
            if (is_icw) base_q <= wdata[DW-1:LW];
            if (is_ocw3 && running) rdsel_q <= wdata[1:0];
        end
    end

    // R2
    running_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R4
    trig_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_TRIG_ARM) |=> $stable(trig_q));

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import prio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t irq_in,
    input  line_vec_t trig,
    input  logic      init,
    input  line_vec_t ack_clr,
    output line_vec_t pend
);

    line_vec_t prev_q, edge_q, rise;

    always_comb begin
        rise = irq_in & ~prev_q & ~trig;
        pend = (trig & irq_in) | (~trig & edge_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            edge_q <= '0;
        end else begin
            prev_q <= irq_in;
            edge_q <= (init ? '0 : (edge_q & ~ack_clr)) | rise;
        end
    end

    // R10
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && ack_clr == '0) |=>
            ((trig != $past(trig)) || (($past(pend) & ~trig & ~pend) == '0)));

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  line_vec_t         pend,
    input  line_vec_t         mask,
    input  logic [BASE_W-1:0] base,
    input  logic              ack,
    input  logic              init,
    input  logic              ns_eoi,
    input  logic              sp_eoi,
    input  logic [LW-1:0]     eoi_lvl,
    output logic              int_out,
    output logic [DW-1:0]     vector_q,
    output line_vec_t         isr_q,
    output line_vec_t         ack_clr
);

    line_vec_t      cand, eoi_clr;
    logic [LW-1:0]  best, top_isr;
    logic           ack_take;

    always_comb begin
        cand     = pend & ~mask;
        best     = first_set(cand);
        top_isr  = first_set(isr_q);
        int_out  = running && (cand != '0) && ((isr_q == '0) || (best < top_isr));
        ack_take = ack && int_out;
        ack_clr  = ack_take ? (line_vec_t'(1) << best) : '0;
        if (ns_eoi && isr_q != '0) eoi_clr = line_vec_t'(1) << top_isr;
        else if (sp_eoi)           eoi_clr = line_vec_t'(1) << eoi_lvl;
        else                       eoi_clr = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q    <= '0;
            vector_q <= '0;
        end else begin
            if (init) isr_q <= '0;
            else      isr_q <= (isr_q & ~eoi_clr) | ack_clr;
            if (ack) vector_q <= {base, (ack_take ? best : LW'(NL - 1))};
        end
    end

    // R6
    ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !init && !ns_eoi && !sp_eoi) |=>
            ($countones(isr_q) == $countones($past(isr_q)) + 1));

    // R7
    spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out && !init && !ns_eoi && !sp_eoi) |=>
            ((vector_q[LW-1:0] == LW'(NL - 1)) && $stable(isr_q)));

    // R8
    eoi_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_eoi && !isr_q[eoi_lvl] && !ack && !init) |=> $stable(isr_q));

    // R9
    nseoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ns_eoi && isr_q != '0 && !ack && !init) |=>
            ($countones(isr_q) + 1 == $countones($past(isr_q))));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  line_vec_t     irq_in,
    input  logic          inta,
    output logic          int_out,
    output logic [DW-1:0] vector_out
);

    logic              running, init_p, ns_eoi_p, sp_eoi_p;
    line_vec_t         mask_q, trig_q, pend, isr_q, ack_clr;
    logic [BASE_W-1:0] base_q;
    logic [1:0]        rdsel_q;
    logic [LW-1:0]     eoi_lvl;

    irq_cmd_fsm u_cmd (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .running(running), .mask_q(mask_q), .trig_q(trig_q), .base_q(base_q),
        .rdsel_q(rdsel_q), .init_p(init_p), .ns_eoi_p(ns_eoi_p),
        .sp_eoi_p(sp_eoi_p), .eoi_lvl(eoi_lvl)
    );

    irq_req_latch u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig(trig_q),
        .init(init_p), .ack_clr(ack_clr), .pend(pend)
    );

    irq_prio_core u_core (
        .clk(clk), .rst_n(rst_n), .running(running), .pend(pend), .mask(mask_q),
        .base(base_q), .ack(inta), .init(init_p), .ns_eoi(ns_eoi_p),
        .sp_eoi(sp_eoi_p), .eoi_lvl(eoi_lvl), .int_out(int_out),
        .vector_q(vector_out), .isr_q(isr_q), .ack_clr(ack_clr)
    );

    always_comb begin
        if (bus_addr) begin
            bus_rdata = DW'(mask_q);
        end else begin
            case (rdsel_q)
                2'd1:    bus_rdata = DW'(pend);
                2'd2:    bus_rdata = DW'(trig_q);
                default: bus_rdata = DW'(isr_q);
            endcase
        end
    end

endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       inta = 1'b0;
    logic       int_out;
    logic [7:0] vector_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .inta(inta), .int_out(int_out), .vector_out(vector_out)
    );

    always #5 clk = ~clk;

    // ---------------- reference model ----------------
    bit         m_run, m_arm;
    logic [7:0] m_mask, m_trig, m_isr, m_edge, m_prev, m_vec;
    logic [4:0] m_base;
    logic [1:0] m_rdsel;

    function automatic bit m_pend(int i);
        return m_trig[i] ? irq_in[i] : m_edge[i];
    endfunction

    function automatic int m_best();
        for (int i = 0; i < 8; i++) if (m_pend(i) && !m_mask[i]) return i;
        return -1;
    endfunction

    function automatic int m_top();
        for (int i = 0; i < 8; i++) if (m_isr[i]) return i;
        return 8;
    endfunction

    function automatic bit m_fire();
        int b;
        b = m_best();
        return m_run && (b >= 0) && (b < m_top());
    endfunction

    function automatic logic [7:0] m_pendvec();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = m_pend(i);
        return v;
    endfunction

    function automatic logic [7:0] m_rd();
        if (bus_addr) return m_mask;
        if (m_rdsel == 2'd1) return m_pendvec();
        if (m_rdsel == 2'd2) return m_trig;
        return m_isr;
    endfunction

    always @(posedge clk) begin
        int b;
        bit f;
        logic [7:0] rise;
        if (!rst_n) begin
            m_run = 0; m_arm = 0; m_mask = 0; m_trig = 0; m_isr = 0;
            m_edge = 0; m_prev = 0; m_vec = 0; m_base = 0; m_rdsel = 0;
        end else begin
            b = m_best();
            f = m_fire();
            rise = irq_in & ~m_prev & ~m_trig;
            if (inta) begin
                if (f) begin
                    m_isr[b]  = 1'b1;
                    m_edge[b] = 1'b0;
                    m_vec = {m_base, 3'(b)};
                end else begin
                    m_vec = {m_base, 3'b111};
                end
            end
            if (bus_wr) begin
                if (bus_addr) begin
                    if (m_arm) begin m_trig = bus_wdata; m_arm = 0; end
                    else m_mask = bus_wdata;
                end else if (bus_wdata[4]) begin
                    m_base = bus_wdata[7:3]; m_isr = 0; m_edge = 0; m_run = 1; m_arm = 0;
                end else if (m_run) begin
                    if (!bus_wdata[3]) begin
                        if (bus_wdata[7:5] == 3'b001 && m_top() < 8) m_isr[m_top()] = 1'b0;
                        if (bus_wdata[7:5] == 3'b011) m_isr[bus_wdata[2:0]] = 1'b0;
                    end else begin
                        m_rdsel = bus_wdata[1:0];
                        if (bus_wdata[2]) m_arm = 1;
                    end
                end
            end
            m_edge = m_edge | rise;
            m_prev = irq_in;
        end
    end

    // every-clock comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (int_out !== m_fire() || vector_out !== m_vec || bus_rdata !== m_rd()) begin
                n_bad++;
                $display("FAIL %s cycle compare: int=%b/%b vec=%h/%h rd=%h/%h (actual/expected)",
                         cur_req, int_out, m_fire(), vector_out, m_vec, bus_rdata, m_rd());
            end
        end
    end

    // ---------------- stimulus helpers (start and end at posedge + 1) ----------------
    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bwr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic ack();
        inta = 1'b1;
        @(posedge clk); #1;
        inta = 1'b0;
    endtask

    task automatic rd(input logic a, input string tag, input logic [7:0] exp);
        bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
        bus_addr = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        #1;
        cur_req = "R1";
        chk("R1 int_out after reset", {7'd0, int_out}, 8'h00);
        chk("R1 vector after reset", vector_out, 8'h00);
        rd(1'b1, "R1 mask after reset", 8'h00);
        irq_in = 8'h08; idle(2);
        chk("R1 no delivery before init", {7'd0, int_out}, 8'h00);
        irq_in = 8'h00; idle(1);

        cur_req = "R2";
        bwr(1'b0, 8'h50);
        chk("R2 stale edge cleared by init", {7'd0, int_out}, 8'h00);
        rd(1'b0, "R2 isr after init", 8'h00);

        cur_req = "R10";
        irq_in = 8'h08; idle(1);
        chk("R10 edge pending next cycle", {7'd0, int_out}, 8'h01);
        irq_in = 8'h00; idle(2);
        chk("R10 edge held after input falls", {7'd0, int_out}, 8'h01);
        cur_req = "R6";
        ack();
        chk("R6 vector base+3", vector_out, 8'h53);
        rd(1'b0, "R6 isr bit3", 8'h08);

        cur_req = "R7";
        ack();
        chk("R7 spurious vector", vector_out, 8'h57);
        rd(1'b0, "R7 isr unchanged", 8'h08);

        cur_req = "R5";
        irq_in = 8'h20; idle(1);
        chk("R5 lower priority held", {7'd0, int_out}, 8'h00);
        cur_req = "R4";
        bwr(1'b0, 8'h09);
        rd(1'b0, "R4 pending readback", 8'h20);
        bwr(1'b0, 8'h08);
        cur_req = "R5";
        irq_in = 8'h22; idle(1);
        chk("R5 higher priority preempts", {7'd0, int_out}, 8'h01);
        ack();
        chk("R5 vector line1", vector_out, 8'h51);
        rd(1'b0, "R5 isr 1 and 3", 8'h0A);
        irq_in = 8'h00; idle(1);

        cur_req = "R9";
        bwr(1'b0, 8'h20);
        rd(1'b0, "R9 non-specific clears line1", 8'h08);
        chk("R9 line5 still held", {7'd0, int_out}, 8'h00);

        cur_req = "R8";
        bwr(1'b0, 8'h63);
        rd(1'b0, "R8 specific clears line3", 8'h00);
        chk("R8 line5 now delivered", {7'd0, int_out}, 8'h01);
        bwr(1'b0, 8'h62);
        rd(1'b0, "R8 eoi on clear level no effect", 8'h00);

        cur_req = "R3";
        bwr(1'b1, 8'h20);
        chk("R3 masked line blocked", {7'd0, int_out}, 8'h00);
        rd(1'b1, "R3 mask readback", 8'h20);
        bwr(1'b1, 8'h00);
        chk("R3 unmasked line delivered", {7'd0, int_out}, 8'h01);
        ack();
        chk("R3 vector line5", vector_out, 8'h55);
        bwr(1'b0, 8'h65);

        cur_req = "R12";
        irq_in = 8'h04; idle(1);
        ack();
        chk("R12 vector line2", vector_out, 8'h52);
        irq_in = 8'h00;
        bwr(1'b0, 8'h40);
        rd(1'b0, "R12 code 010 ignored", 8'h04);
        bwr(1'b0, 8'hE0);
        rd(1'b0, "R12 code 111 ignored", 8'h04);
        bwr(1'b0, 8'h62);

        cur_req = "R4";
        bwr(1'b0, 8'h0E);
        bwr(1'b1, 8'h01);
        rd(1'b0, "R4 trigger readback", 8'h01);
        rd(1'b1, "R4 mask untouched by trigger load", 8'h00);

        cur_req = "R11";
        irq_in = 8'h01; #1;
        chk("R11 level request immediate", {7'd0, int_out}, 8'h01);
        idle(1);
        ack();
        chk("R11 vector line0", vector_out, 8'h50);
        chk("R11 in service blocks", {7'd0, int_out}, 8'h00);
        bwr(1'b0, 8'h60);
        chk("R11 level re-request after eoi", {7'd0, int_out}, 8'h01);
        irq_in = 8'h00; #1;
        chk("R11 level drops with input", {7'd0, int_out}, 8'h00);
        idle(1);

        cur_req = "R10";
        irq_in = 8'h40; idle(1);
        ack();
        chk("R10 vector line6", vector_out, 8'h56);
        bwr(1'b0, 8'h66);
        idle(2);
        chk("R10 held edge line not redelivered", {7'd0, int_out}, 8'h00);
        irq_in = 8'h00; idle(1);

        cur_req = "R2";
        irq_in = 8'h10; idle(1);
        ack();
        irq_in = 8'h00;
        bwr(1'b0, 8'h08);
        rd(1'b0, "R2 isr before reinit", 8'h10);
        bwr(1'b0, 8'h98);
        rd(1'b0, "R2 reinit clears isr", 8'h00);
        ack();
        chk("R2 new base in vector", vector_out, 8'h9F);

        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule